// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Block

This block keeps the interrupt status flags and the interrupt enable mask of a USB 2.0 host controller and drives one interrupt request line. Event pulses arrive from the transfer engine, the port logic, the frame counter and the system-bus error detector. Each pulse sets a sticky status flag. Software reads the flags through a simple 32-bit register port and acknowledges an event by writing a one to its flag.

Sources fall into two groups. Port change, frame-list rollover and host system error raise the line as soon as the flag and its enable are both set. Transfer completion, transfer error and async-advance are deferred. They are latched into a pending register on the interrupt-threshold tick, which an external micro-frame timer supplies. Only then do they raise the line. Clearing a deferred flag also removes its pending copy, so an event that software has already acknowledged cannot fire later.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After synchronous reset, the status flags, the enable mask, `irq` and `reg_rdata` are all zero.
- R2: The enable register sits at address 0x18. A write stores bits 5:0, and bits 31:6 always read as zero.
- R3: The status register sits at address 0x14, with the flag bits 0 done, 1 error, 2 port change, 3 rollover, 4 system error and 5 async advance. `reg_rdata` shows the addressed register one cycle after `reg_addr` is presented. Reserved bits and unmapped addresses read zero.
- R4: Flag 0 sets on a pulse of `ev_ioc_retire` or of `ev_short_pkt`.
- R5: A pulse of `ev_xact_err` sets flag 1. If `ev_err_ioc` is high in the same cycle, flag 0 is set as well.
- R6: Flag 2 sets on a pulse of `ev_port_chg` or of `ev_conn_released`. Flags 3, 4 and 5 set on `ev_frame_roll`, `ev_sys_err` and `ev_async_adv`.
- R7: Writing to the status address clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: For flags 2, 3 and 4, `irq` goes high on the second clock edge after the event pulse, provided the flag's enable bit is 1.
- R10: For flags 0, 1 and 5, `irq` goes high only on the edge after a threshold tick that found the flag and its enable both 1. Without a tick it stays low.
- R11: Clearing a deferred flag discards its pending copy. A later set of the same flag stays silent until the next tick.
- R12: Once software clears the last enabled active flag, `irq` falls one edge after the clearing write takes effect.
- R13: A flag whose enable bit is 0 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ioc_retire | input | 1 | Descriptor with completion-interrupt flag retired |
| ev_short_pkt | input | 1 | Short packet received |
| ev_xact_err | input | 1 | Transaction ended in error |
| ev_err_ioc | input | 1 | Erroring descriptor also carried the completion-interrupt flag |
| ev_port_chg | input | 1 | Port status change |
| ev_conn_released | input | 1 | Connect change on a port released by software |
| ev_frame_roll | input | 1 | Frame list index rolled over |
| ev_sys_err | input | 1 | Host system bus error |
| ev_async_adv | input | 1 | Async schedule advance doorbell |
| thr_tick | input | 1 | Interrupt-threshold boundary pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit data path, and the two registers at 0x14 and 0x18. With these values the bench can write all-ones patterns that reach the reserved bits. It can also read unmapped addresses such as 0x00 and expect zero. Every other address is then decoded as a miss, so random register traffic exercises both the decode hits and the miss path together with collisions between event sets and clears.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NSRC       = 6;
  localparam int IDX_DONE   = 0;
  localparam int IDX_ERR    = 1;
  localparam int IDX_PORT   = 2;
  localparam int IDX_ROLL   = 3;
  localparam int IDX_SYSERR = 4;
  localparam int IDX_ASYNC  = 5;
  // deferred sources wait for the threshold tick; the rest fire at once
  localparam logic [NSRC-1:0] DEFER_MASK = (NSRC'(1) << IDX_DONE)
                                         | (NSRC'(1) << IDX_ERR)
                                         | (NSRC'(1) << IDX_ASYNC);
  localparam logic [NSRC-1:0] IMM_MASK   = ~DEFER_MASK;
endpackage

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] sts_q,
  output logic [NSRC-1:0] sts_next
);
  // set has priority over a same-cycle clear
  always_comb sts_next = (sts_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_next;
  end
endmodule

// File: rtl/usb_irq_defer.sv
module usb_irq_defer
  import usb_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            thr_tick,
  input  logic [NSRC-1:0] sts_q,
  input  logic [NSRC-1:0] sts_next,
  input  logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (DEFER_MASK[i]) begin : g_pend
      logic p_q;
      always_ff @(posedge clk) begin
        if (rst)               p_q <= 1'b0;
        else if (!sts_next[i]) p_q <= 1'b0;
        else if (thr_tick)     p_q <= sts_q[i] & en_q[i];
      end
      assign pend_q[i] = p_q;
    end else begin : g_none
      assign pend_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_regport.sv
module usb_irq_regport
  import usb_irq_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   sts_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   clr_vec,
  output logic [DATA_W-1:0] reg_rdata
);
  logic hit_sts, hit_ena;
  logic [DATA_W-1:0] rd_next;
  logic unused_wdata;

  assign hit_sts = (reg_addr == STS_ADDR);
  assign hit_ena = (reg_addr == ENA_ADDR);
  assign clr_vec = (reg_wr && hit_sts) ? reg_wdata[NSRC-1:0] : '0;
  assign unused_wdata = ^reg_wdata[DATA_W-1:NSRC];

  always_comb begin
    rd_next = '0;
    if (hit_sts)      rd_next[NSRC-1:0] = sts_q;
    else if (hit_ena) rd_next[NSRC-1:0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && hit_ena) en_q <= reg_wdata[NSRC-1:0];
      reg_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_ioc_retire,
  input  logic              ev_short_pkt,
  input  logic              ev_xact_err,
  input  logic              ev_err_ioc,
  input  logic              ev_port_chg,
  input  logic              ev_conn_released,
  input  logic              ev_frame_roll,
  input  logic              ev_sys_err,
  input  logic              ev_async_adv,
  input  logic              thr_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NSRC-1:0] set_vec, clr_vec, sts_q, sts_next, en_q, pend_q;

  always_comb begin
    set_vec             = '0;
    set_vec[IDX_DONE]   = ev_ioc_retire | ev_short_pkt | (ev_xact_err & ev_err_ioc);
    set_vec[IDX_ERR]    = ev_xact_err;
    set_vec[IDX_PORT]   = ev_port_chg | ev_conn_released;
    set_vec[IDX_ROLL]   = ev_frame_roll;
    set_vec[IDX_SYSERR] = ev_sys_err;
    set_vec[IDX_ASYNC]  = ev_async_adv;
  end

  usb_irq_status u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .sts_q(sts_q), .sts_next(sts_next)
  );

  usb_irq_regport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_ADDR(STS_ADDR), .ENA_ADDR(ENA_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sts_q(sts_q), .en_q(en_q),
    .clr_vec(clr_vec), .reg_rdata(reg_rdata)
  );

  usb_irq_defer u_defer (
    .clk(clk), .rst(rst), .thr_tick(thr_tick), .sts_q(sts_q),
    .sts_next(sts_next), .en_q(en_q), .pend_q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (|(sts_q & en_q & IMM_MASK)) | (|(pend_q & en_q));
  end
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
  import usb_irq_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h14
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              thr_tick,
  input logic [NSRC-1:0]   sts_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   set_vec,
  input logic [DATA_W-1:0] reg_rdata
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && sts_q == '0 && en_q == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:NSRC] == '0);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  a_r7_fall_needs_write: assert property (@(posedge clk) disable iff (rst)
    (|($past(sts_q) & ~sts_q)) |-> $past(reg_wr && reg_addr == STS_ADDR));

  a_r10_pend_on_tick: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~$past(pend_q))) |-> $past(thr_tick));

  a_r13_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((|(sts_q & en_q & IMM_MASK)) || (|(pend_q & en_q))));
endmodule

bind usb_irq_ctrl usb_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_ADDR(STS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .thr_tick(thr_tick), .sts_q(sts_q), .en_q(en_q), .pend_q(pend_q),
  .set_vec(set_vec), .reg_rdata(reg_rdata)
);

// File: tb/usb_irq_ctrl_test.sv
`timescale 1ns/1ps
module usb_irq_ctrl_test;
  localparam logic [7:0] A_STS = 8'h14;
  localparam logic [7:0] A_ENA = 8'h18;

  logic clk = 0, rst = 1;
  logic ev_ioc_retire = 0, ev_short_pkt = 0, ev_xact_err = 0, ev_err_ioc = 0;
  logic ev_port_chg = 0, ev_conn_released = 0, ev_frame_roll = 0, ev_sys_err = 0;
  logic ev_async_adv = 0, thr_tick = 0, reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_irq_ctrl uut (
    .clk(clk), .rst(rst), .ev_ioc_retire(ev_ioc_retire), .ev_short_pkt(ev_short_pkt),
    .ev_xact_err(ev_xact_err), .ev_err_ioc(ev_err_ioc), .ev_port_chg(ev_port_chg),
    .ev_conn_released(ev_conn_released), .ev_frame_roll(ev_frame_roll),
    .ev_sys_err(ev_sys_err), .ev_async_adv(ev_async_adv), .thr_tick(thr_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference: flags, mask, latched deferred flags, line, read data
  bit [5:0] m_sts, m_en, m_lat;
  bit       m_irq;
  bit [31:0] m_rd;

  always @(posedge clk) begin
    bit [5:0] s_new, hwset, swclr, l_new;
    bit       line;
    if (rst) begin
      m_sts = 0; m_en = 0; m_lat = 0; m_irq = 0; m_rd = 0;
    end else begin
      hwset = {ev_async_adv, ev_sys_err, ev_frame_roll, ev_port_chg || ev_conn_released,
               ev_xact_err, ev_ioc_retire || ev_short_pkt || (ev_xact_err && ev_err_ioc)};
      swclr = (reg_wr && reg_addr == A_STS) ? reg_wdata[5:0] : 6'd0;
      s_new = 0;
      for (int b = 0; b < 6; b++) s_new[b] = hwset[b] ? 1'b1 : (swclr[b] ? 1'b0 : m_sts[b]);
      l_new = m_lat;
      for (int b = 0; b < 6; b++) begin
        if (b == 0 || b == 1 || b == 5) begin
          if (thr_tick) l_new[b] = m_sts[b] && m_en[b];
          if (!s_new[b]) l_new[b] = 0;
        end
      end
      line = 0;
      for (int b = 0; b < 6; b++) begin
        if ((b == 2 || b == 3 || b == 4) && m_sts[b] && m_en[b]) line = 1;
        if (m_lat[b] && m_en[b]) line = 1;
      end
      m_rd = (reg_addr == A_STS) ? {26'd0, m_sts} : (reg_addr == A_ENA) ? {26'd0, m_en} : 32'd0;
      if (reg_wr && reg_addr == A_ENA) m_en = reg_wdata[5:0];
      m_sts = s_new; m_lat = l_new; m_irq = line;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model (R12 line, R3 read data)
  always @(negedge clk) if (!rst && !done) begin
    check("R12", {31'd0, irq}, {31'd0, m_irq});
    check("R3", reg_rdata, m_rd);
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(1);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; cyc(1); d = reg_rdata;
  endtask

  task automatic clr_all(); wr(A_STS, 32'h3F); endtask

  logic [31:0] v;

  initial begin
    cyc(4); rst = 0;
    check("R1", {31'd0, irq}, 0);
    check("R1", reg_rdata, 0);
    rd(A_STS, v); check("R1", v, 0);
    rd(A_ENA, v); check("R1", v, 0);

    wr(A_ENA, 32'hFFFF_FFFF); rd(A_ENA, v); check("R2", v, 32'h3F);
    rd(8'h00, v); check("R3", v, 0);
    wr(A_ENA, 0);

    ev_ioc_retire = 1; cyc(1); ev_ioc_retire = 0;
    rd(A_STS, v); check("R4", v, 32'h01);
    wr(A_STS, 32'h0); rd(A_STS, v); check("R7", v, 32'h01);
    wr(A_STS, 32'h1); rd(A_STS, v); check("R7", v, 32'h00);
    ev_short_pkt = 1; cyc(1); ev_short_pkt = 0;
    rd(A_STS, v); check("R4", v, 32'h01); clr_all();

    ev_xact_err = 1; ev_err_ioc = 1; cyc(1); ev_xact_err = 0; ev_err_ioc = 0;
    rd(A_STS, v); check("R5", v, 32'h03); clr_all();
    ev_xact_err = 1; cyc(1); ev_xact_err = 0;
    rd(A_STS, v); check("R5", v, 32'h02); clr_all();

    ev_conn_released = 1; cyc(1); ev_conn_released = 0;
    rd(A_STS, v); check("R6", v, 32'h04); clr_all();
    ev_port_chg = 1; ev_frame_roll = 1; ev_sys_err = 1; ev_async_adv = 1; cyc(1);
    ev_port_chg = 0; ev_frame_roll = 0; ev_sys_err = 0; ev_async_adv = 0;
    rd(A_STS, v); check("R6", v, 32'h3C);
    thr_tick = 1; cyc(1); thr_tick = 0; cyc(3);
    check("R13", {31'd0, irq}, 0);
    clr_all();

    // same-cycle set and clear on the rollover flag
    ev_frame_roll = 1; reg_wr = 1; reg_addr = A_STS; reg_wdata = 32'h08; cyc(1);
    ev_frame_roll = 0; reg_wr = 0; reg_wdata = 0;
    rd(A_STS, v); check("R8", v, 32'h08); clr_all();

    wr(A_ENA, 32'h1C);
    ev_sys_err = 1; cyc(1); ev_sys_err = 0;
    check("R9", {31'd0, irq}, 0);
    cyc(1); check("R9", {31'd0, irq}, 1);
    wr(A_STS, 32'h10);
    check("R12", {31'd0, irq}, 1);
    cyc(1); check("R12", {31'd0, irq}, 0);

    wr(A_ENA, 32'h23);
    ev_async_adv = 1; cyc(1); ev_async_adv = 0; cyc(5);
    check("R10", {31'd0, irq}, 0);
    thr_tick = 1; cyc(1); thr_tick = 0;
    check("R10", {31'd0, irq}, 0);
    cyc(1); check("R10", {31'd0, irq}, 1);
    wr(A_STS, 32'h20); cyc(1); check("R12", {31'd0, irq}, 0);

    ev_ioc_retire = 1; cyc(1); ev_ioc_retire = 0;
    thr_tick = 1; cyc(1); thr_tick = 0; cyc(1);
    check("R10", {31'd0, irq}, 1);
    wr(A_STS, 32'h01); cyc(1);
    ev_ioc_retire = 1; cyc(1); ev_ioc_retire = 0; cyc(4);
    check("R11", {31'd0, irq}, 0);
    clr_all();

    for (int i = 0; i < 3000; i++) begin
      ev_ioc_retire = ($urandom % 16) == 0; ev_short_pkt = ($urandom % 20) == 0;
      ev_xact_err = ($urandom % 16) == 0;   ev_err_ioc = $urandom % 2;
      ev_port_chg = ($urandom % 20) == 0;   ev_conn_released = ($urandom % 25) == 0;
      ev_frame_roll = ($urandom % 20) == 0; ev_sys_err = ($urandom % 30) == 0;
      ev_async_adv = ($urandom % 18) == 0;  thr_tick = ($urandom % 8) == 0;
      reg_wr = ($urandom % 6) == 0;
      case ($urandom % 3)
        0: reg_addr = A_STS;
        1: reg_addr = A_ENA;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wdata = $urandom;
      cyc(1);
    end
    {ev_ioc_retire, ev_short_pkt, ev_xact_err, ev_err_ioc, ev_port_chg} = '0;
    {ev_conn_released, ev_frame_roll, ev_sys_err, ev_async_adv, thr_tick, reg_wr} = '0;
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule